// File: doc/BRIEF.md
# Fuse Word Lock and Access Filter

This block keeps the lock state for an array of one-time-programmable fuse words. The array itself lives elsewhere. For every word it holds four independent sticky lock bits: permanent-write, program, shadow-write and shadow-read. It also holds a small global lock register with three services. A register port sets and reads this state. Lock bitmaps are laid out as 32-bit banks, and each word is located by its bank (index divided by 32) and its bit (index modulo 32).

The words are split at a configurable upper base. Words below it are open to any requester. Words at or above it may be reached by a non-secure requester only when a grant bitmap allows it. The grant bitmap is indexed from the upper base. It is filled by secure register writes while it is open. A lock-down pulse seals it, and it then stays unchanged until reset.

A query port takes a word index, a lock kind and a security attribute. One cycle later it returns the selected lock bit, the access grant and a range error. The sealing logic is a two-state machine. In GM_OPEN, grant writes are accepted. The transition GM_OPEN to GM_FROZEN happens on the `grant_lock` pulse. GM_FROZEN is final until reset.

Top module: `fuse_lock_filter`

## Requirements
- R1: After reset, every lock bank, the global lock register and every grant bank read as 0, and `reg_rsp`, `reg_err`, `q_rsp_valid`, `q_locked`, `q_grant` and `q_err` are 0.
- R2: The lock bank for word i of a kind sits at the kind base plus 4*(i/32), and the word's bit in that bank is i%32. The kind bases are 0x04C for permanent-write, 0x064 for program, 0x07C for shadow-write and 0x094 for shadow-read.
- R3: Lock bits are write-1-to-set. A written 0 leaves a bit unchanged, and only reset clears it.
- R4: A write to one kind's bank changes no other kind's bits.
- R5: The global lock register is at 0x010. A write of exactly 0x01 (upper words), 0x04 (debug) or 0x10 (programming) sets that bit. Any other written value is rejected with `reg_err`=1 and changes nothing. Set bits stay set.
- R6: A query whose index is above NUM_WORDS-1 returns `q_err`=1, `q_locked`=0 and `q_grant`=0.
- R7: For an in-range index, `q_locked` is the word's bit of the kind chosen by `q_kind`: 0 is permanent-write, 1 is program, 2 is shadow-write and 3 is shadow-read.
- R8: An in-range query is granted when `q_secure`=1, or when the index is below UPPER_BASE, or when grant bit (index-UPPER_BASE) is set.
- R9: Grant banks are at 0x0C0 plus 4*bank, and they are write-1-to-set. A write with `reg_secure`=0 is rejected with `reg_err`=1 and changes nothing.
- R10: After a `grant_lock` pulse, every grant write is rejected with `reg_err`=1, and the grant bitmap stays unchanged until reset.
- R11: An access to an unmapped or misaligned address, or to a bank beyond the bitmap, returns `reg_err`=1 with `reg_rdata`=0.
- R12: A register access is answered by `reg_rsp`, and a query by `q_rsp_valid`, exactly one clock cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_secure | input | 1 | Security attribute of the register access |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rsp | output | 1 | Register response strobe |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | Access rejected |
| grant_lock | input | 1 | Lock-down pulse that seals the grant bitmap |
| q_req | input | 1 | Query request |
| q_idx | input | IDX_W | Word index to query |
| q_kind | input | 2 | Lock kind selector |
| q_secure | input | 1 | Security attribute of the query |
| q_rsp_valid | output | 1 | Query response strobe |
| q_locked | output | 1 | Selected lock bit |
| q_grant | output | 1 | Access grant |
| q_err | output | 1 | Index out of range |

## Verification
The hardest situation to reach from the ports is the sealed grant map. It must hold bits on both sides of the lower/upper boundary while writes that try to change it are rejected, and a permanent-write lock must show up only when its kind is selected. The stimulus first lays different, arithmetic lock patterns into all four kinds and then writes zeros over every bank. Next it fills the grant banks with a secure write, tries a non-secure write, seals the map and attempts a further secure write. Finally it sweeps every word index, plus a few beyond the top, across all kinds and both security attributes.

// File: rtl/fuse_lock_pkg.sv
package fuse_lock_pkg;

    localparam int REG_AW    = 12;
    localparam int REG_DW    = 32;
    localparam int NUM_KINDS = 4;
    localparam int BANK_BITS = 32;

    typedef enum logic [1:0] {
        LK_PERM = 2'd0,
        LK_PROG = 2'd1,
        LK_SHW  = 2'd2,
        LK_SHR  = 2'd3
    } lock_kind_e;

    typedef enum logic {
        GM_OPEN   = 1'b0,
        GM_FROZEN = 1'b1
    } gmap_state_e;

    localparam logic [31:0] GLOCK_OFS  = 32'h010;
    localparam logic [31:0] GRANT_OFS  = 32'h0C0;
    localparam logic [31:0] GLOCK_MASK = 32'h0000_0015;

    function automatic logic [31:0] kind_base(input int k);
        case (k)
            0:       return 32'h04C;
            1:       return 32'h064;
            2:       return 32'h07C;
            default: return 32'h094;
        endcase
    endfunction

    function automatic logic glock_legal(input logic [31:0] v);
        return (v == 32'h01) || (v == 32'h04) || (v == 32'h10);
    endfunction

endpackage

// File: rtl/fuse_lock_bitmap.sv
module fuse_lock_bitmap #(
    parameter int NBITS  = 96,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [31:0]       set_mask,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [31:0]       rd_word,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              bit_val
);
    localparam int NBANK = (NBITS + 31) / 32;
    localparam int TOT   = NBANK * 32;

    function automatic logic [TOT-1:0] valid_mask();
        logic [TOT-1:0] v;
        for (int i = 0; i < TOT; i++) v[i] = (i < NBITS);
        return v;
    endfunction

    localparam logic [TOT-1:0] VALID = valid_mask();

    logic [TOT-1:0] bits_q;
    logic [TOT-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_en && (32'(set_bank) < NBANK))
            set_vec = (TOT'(set_mask) << {set_bank, 5'b0}) & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_q | set_vec;
    end

    always_comb begin
        rd_word = '0;
        if (32'(rd_bank) < NBANK) rd_word = 32'(bits_q >> {rd_bank, 5'b0});
        bit_val = |(bits_q & (TOT'(1) << bit_idx));
    end

endmodule

// File: rtl/fuse_grant_map.sv
module fuse_grant_map
    import fuse_lock_pkg::*;
#(
    parameter int NBITS  = 64,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seal,
    input  logic              cfg_wr,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [31:0]       cfg_mask,
    output logic              cfg_open,
    output logic              frozen,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [31:0]       rd_word,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              bit_val
);
    gmap_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GM_OPEN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GM_OPEN:   if (seal) st_d = GM_FROZEN;
            GM_FROZEN: st_d = GM_FROZEN;
        endcase
    end

    always_comb begin
        cfg_open = (st_q == GM_OPEN);
        frozen   = (st_q == GM_FROZEN);
    end

    fuse_lock_bitmap #(.NBITS(NBITS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (cfg_wr && cfg_open),
        .set_bank (cfg_bank),
        .set_mask (cfg_mask),
        .rd_bank  (rd_bank),
        .rd_word  (rd_word),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val)
    );

endmodule

// File: rtl/fuse_lock_filter.sv
module fuse_lock_filter
    import fuse_lock_pkg::*;
#(
    parameter int NUM_WORDS  = 96,
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_secure,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_rsp,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic              grant_lock,
    input  logic              q_req,
    input  logic [IDX_W-1:0]  q_idx,
    input  logic [1:0]        q_kind,
    input  logic              q_secure,
    output logic              q_rsp_valid,
    output logic              q_locked,
    output logic              q_grant,
    output logic              q_err
);
    localparam int GW     = NUM_WORDS - UPPER_BASE;
    localparam int NBANK  = (NUM_WORDS + 31) / 32;
    localparam int GBANK  = (GW + 31) / 32;
    localparam int MAXB   = (NBANK > GBANK) ? NBANK : GBANK;
    localparam int BANK_W = $clog2(MAXB + 1);
    localparam logic [31:0] NW_U = 32'(NUM_WORDS);
    localparam logic [31:0] UB_U = 32'(UPPER_BASE);

    logic [31:0]          addr32;
    logic [NUM_KINDS-1:0] kind_hit;
    logic                 glock_hit, grant_hit;
    logic [BANK_W-1:0]    bank_sel, gbank_sel;
    logic [31:0]          kind_words [NUM_KINDS];
    logic [NUM_KINDS-1:0] kind_bits;
    logic [31:0]          grant_word;
    logic                 grant_bit, grant_open, gm_frozen;
    logic [31:0]          glock_q;
    logic                 req, acc_err, glock_ok;
    logic [31:0]          rd_mux;

    assign addr32 = 32'(reg_addr);
    assign req    = reg_wr || reg_rd;

    // Address decode: one kind window, the grant window or the global lock.
    always_comb begin
        kind_hit  = '0;
        bank_sel  = '0;
        gbank_sel = '0;
        grant_hit = 1'b0;
        glock_hit = (addr32 == GLOCK_OFS);
        for (int k = 0; k < NUM_KINDS; k++) begin
            if ((addr32[1:0] == 2'b00) && (addr32 >= kind_base(k)) &&
                (addr32 < kind_base(k) + 32'(4 * NBANK))) begin
                kind_hit[k] = 1'b1;
                bank_sel    = BANK_W'((addr32 - kind_base(k)) >> 2);
            end
        end
        if ((addr32[1:0] == 2'b00) && (addr32 >= GRANT_OFS) &&
            (addr32 < GRANT_OFS + 32'(4 * GBANK))) begin
            grant_hit = 1'b1;
            gbank_sel = BANK_W'((addr32 - GRANT_OFS) >> 2);
        end
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : gen_kind
        fuse_lock_bitmap #(.NBITS(NUM_WORDS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (reg_wr && kind_hit[k]),
            .set_bank (bank_sel),
            .set_mask (reg_wdata),
            .rd_bank  (bank_sel),
            .rd_word  (kind_words[k]),
            .bit_idx  (q_idx),
            .bit_val  (kind_bits[k])
        );
    end

    fuse_grant_map #(.NBITS(GW), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal     (grant_lock),
        .cfg_wr   (reg_wr && grant_hit && reg_secure),
        .cfg_bank (gbank_sel),
        .cfg_mask (reg_wdata),
        .cfg_open (grant_open),
        .frozen   (gm_frozen),
        .rd_bank  (gbank_sel),
        .rd_word  (grant_word),
        .bit_idx  (q_idx - IDX_W'(UPPER_BASE)),
        .bit_val  (grant_bit)
    );

    assign glock_ok = glock_legal(reg_wdata);

    always_ff @(posedge clk) begin
        if (!rst_n) glock_q <= '0;
        else if (reg_wr && glock_hit && glock_ok)
            glock_q <= glock_q | (reg_wdata & GLOCK_MASK);
    end

    always_comb begin
        acc_err = !(|kind_hit || glock_hit || grant_hit);
        if (reg_wr && glock_hit && !glock_ok) acc_err = 1'b1;
        if (reg_wr && grant_hit && !(reg_secure && grant_open)) acc_err = 1'b1;
        rd_mux = '0;
        for (int k = 0; k < NUM_KINDS; k++)
            if (kind_hit[k]) rd_mux = kind_words[k];
        if (glock_hit) rd_mux = glock_q;
        if (grant_hit) rd_mux = grant_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rsp   <= 1'b0;
            reg_err   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_rsp   <= req;
            reg_err   <= req && acc_err;
            reg_rdata <= (reg_rd && !reg_wr && !acc_err) ? rd_mux : '0;
        end
    end

    // Query pipeline: one register stage.
    logic q_in_range, q_lower;
    assign q_in_range = (32'(q_idx) < NW_U);
    assign q_lower    = (32'(q_idx) < UB_U);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rsp_valid <= 1'b0;
            q_locked    <= 1'b0;
            q_grant     <= 1'b0;
            q_err       <= 1'b0;
        end else begin
            q_rsp_valid <= q_req;
            if (q_req) begin
                q_err    <= !q_in_range;
                q_locked <= q_in_range && kind_bits[q_kind];
                q_grant  <= q_in_range && (q_secure || q_lower || grant_bit);
            end
        end
    end

endmodule

// File: rtl/fuse_lock_filter_chk.sv
module fuse_lock_filter_chk #(
    parameter int NUM_WORDS  = 96,
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             reg_rsp,
    input logic             reg_err,
    input logic [31:0]      reg_rdata,
    input logic             q_req,
    input logic [IDX_W-1:0] q_idx,
    input logic             q_secure,
    input logic             q_rsp_valid,
    input logic             q_locked,
    input logic             q_grant,
    input logic             q_err,
    input logic [31:0]      glock_q,
    input logic             gm_frozen
);
    p_reg_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> reg_rsp);

    p_reg_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr || reg_rd) |=> !reg_rsp);

    p_q_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        q_req |=> q_rsp_valid);

    p_qerr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_rsp_valid && q_err) |-> (!q_grant && !q_locked));

    p_secure_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_req && q_secure && (32'(q_idx) < 32'(NUM_WORDS))) |=> q_grant);

    p_lower_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_req && (32'(q_idx) < 32'(UPPER_BASE))) |=> q_grant);

    p_glock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((glock_q & $past(glock_q)) == $past(glock_q)));

    p_seal_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gm_frozen |=> gm_frozen);

    p_err_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rsp && reg_err) |-> (reg_rdata == 32'h0));

endmodule

bind fuse_lock_filter fuse_lock_filter_chk #(
    .NUM_WORDS(NUM_WORDS), .UPPER_BASE(UPPER_BASE), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rsp(reg_rsp), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .q_req(q_req), .q_idx(q_idx), .q_secure(q_secure),
    .q_rsp_valid(q_rsp_valid), .q_locked(q_locked), .q_grant(q_grant),
    .q_err(q_err), .glock_q(glock_q), .gm_frozen(gm_frozen)
);

// File: tb/fuse_lock_filter_tb_top.sv
`timescale 1ns/1ps
module fuse_lock_filter_tb_top;
    localparam int NW = 96;
    localparam int UB = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_secure = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_rsp, reg_err;
    logic [31:0]   reg_rdata;
    logic          grant_lock = 1'b0;
    logic          q_req = 1'b0, q_secure = 1'b0;
    logic [IW-1:0] q_idx = '0;
    logic [1:0]    q_kind = '0;
    logic          q_rsp_valid, q_locked, q_grant, q_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    fuse_lock_filter #(.NUM_WORDS(NW), .UPPER_BASE(UB), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_secure(reg_secure), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rsp(reg_rsp), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .grant_lock(grant_lock), .q_req(q_req), .q_idx(q_idx), .q_kind(q_kind),
        .q_secure(q_secure), .q_rsp_valid(q_rsp_valid), .q_locked(q_locked),
        .q_grant(q_grant), .q_err(q_err)
    );

    function automatic logic [11:0] lbase(input int k);
        return 12'(32'h04C + 32'h018 * k);
    endfunction

    function automatic bit exp_lock(input int k, input int idx);
        return (idx < NW) && (idx % (k + 3) == 0);
    endfunction

    function automatic logic [31:0] exp_bank(input int k, input int b);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++) w[i] = exp_lock(k, b * 32 + i);
        return w;
    endfunction

    localparam logic [63:0] GRANT_PAT = {32'h8000_0001, 32'h0000_F00F};

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_op(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          input bit sec, output logic [31:0] rd, output logic er,
                          output logic rsp);
        @(negedge clk);
        reg_wr = wr; reg_rd = !wr; reg_addr = a; reg_wdata = d; reg_secure = sec;
        @(negedge clk);
        rd = reg_rdata; er = reg_err; rsp = reg_rsp;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic query(input int idx, input int k, input bit sec,
                         output logic lk, output logic gr, output logic er,
                         output logic vl);
        @(negedge clk);
        q_req = 1'b1; q_idx = IW'(idx); q_kind = 2'(k); q_secure = sec;
        @(negedge clk);
        lk = q_locked; gr = q_grant; er = q_err; vl = q_rsp_valid;
        q_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er, rsp, lk, gr, qe, vl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset outputs
        chk({reg_rsp, reg_err, q_rsp_valid, q_locked, q_grant, q_err} == 6'b0,
            "R1 reset outputs",
            {reg_rsp, reg_err, q_rsp_valid, q_locked, q_grant, q_err}, 0);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 3; b++) begin
                reg_op(1'b0, lbase(k) + 12'(4 * b), 0, 1'b1, rd, er, rsp);
                chk(rd == 0 && !er, "R1 lock bank reset", rd, 0);
            end
        reg_op(1'b0, 12'h010, 0, 1'b1, rd, er, rsp);
        chk(rd == 0, "R1 global lock reset", rd, 0);
        for (int b = 0; b < 2; b++) begin
            reg_op(1'b0, 12'h0C0 + 12'(4 * b), 0, 1'b1, rd, er, rsp);
            chk(rd == 0, "R1 grant bank reset", rd, 0);
        end

        // R2/R4: single-bit sets per kind with distinct patterns
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < NW; i++)
                if (exp_lock(k, i)) begin
                    reg_op(1'b1, lbase(k) + 12'(4 * (i / 32)), 32'h1 << (i % 32),
                           1'b0, rd, er, rsp);
                    if (i < 2) chk(rsp && !er, "R12 write response", {rsp, er}, 2'b10);
                end
        // R3: zero writes have no effect
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 3; b++)
                reg_op(1'b1, lbase(k) + 12'(4 * b), 0, 1'b0, rd, er, rsp);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 3; b++) begin
                reg_op(1'b0, lbase(k) + 12'(4 * b), 0, 1'b0, rd, er, rsp);
                chk(rd == exp_bank(k, b), "R2 R3 R4 lock bank readback", rd,
                    exp_bank(k, b));
            end

        // R6/R7: query sweep over all kinds
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < NW + 4; i++) begin
                query(i, k, 1'b1, lk, gr, qe, vl);
                chk(vl && lk == exp_lock(k, i) && qe == (i >= NW),
                    (i >= NW) ? "R6 out-of-range query" : "R7 lock query",
                    {vl, lk, qe}, {1'b1, exp_lock(k, i), i >= NW});
            end

        // R11: unmapped, misaligned, beyond-bank
        reg_op(1'b0, 12'h000, 0, 1'b1, rd, er, rsp);
        chk(er && rd == 0, "R11 unmapped read", {er, rd}, {1'b1, 32'h0});
        reg_op(1'b0, lbase(0) + 12'd12, 0, 1'b1, rd, er, rsp);
        chk(er && rd == 0, "R11 bank beyond bitmap", {er, rd}, {1'b1, 32'h0});
        reg_op(1'b0, 12'h011, 0, 1'b1, rd, er, rsp);
        chk(er && rd == 0, "R11 misaligned", {er, rd}, {1'b1, 32'h0});
        reg_op(1'b1, lbase(1) + 12'd2, 32'hFFFF_FFFF, 1'b1, rd, er, rsp);
        chk(er, "R11 misaligned write", er, 1);
        reg_op(1'b0, lbase(1), 0, 1'b1, rd, er, rsp);
        chk(rd == exp_bank(1, 0), "R11 misaligned write ignored", rd, exp_bank(1, 0));

        // R5: global lock services
        reg_op(1'b1, 12'h010, 32'h3, 1'b1, rd, er, rsp);
        chk(er, "R5 two services rejected", er, 1);
        reg_op(1'b1, 12'h010, 32'h2, 1'b1, rd, er, rsp);
        chk(er, "R5 bad service rejected", er, 1);
        reg_op(1'b0, 12'h010, 0, 1'b1, rd, er, rsp);
        chk(rd == 0, "R5 rejected write left no bits", rd, 0);
        reg_op(1'b1, 12'h010, 32'h4, 1'b1, rd, er, rsp);
        chk(!er, "R5 debug service accepted", er, 0);
        reg_op(1'b1, 12'h010, 32'h1, 1'b0, rd, er, rsp);
        reg_op(1'b1, 12'h010, 32'h0, 1'b1, rd, er, rsp);
        chk(er, "R5 zero rejected", er, 1);
        reg_op(1'b0, 12'h010, 0, 1'b1, rd, er, rsp);
        chk(rd == 32'h5, "R5 global lock sticky", rd, 32'h5);
        reg_op(1'b1, 12'h010, 32'h10, 1'b1, rd, er, rsp);
        reg_op(1'b0, 12'h010, 0, 1'b1, rd, er, rsp);
        chk(rd == 32'h15, "R5 all services", rd, 32'h15);

        // R9: grant configuration
        reg_op(1'b1, 12'h0C0, 32'hFFFF_FFFF, 1'b0, rd, er, rsp);
        chk(er, "R9 non-secure grant write rejected", er, 1);
        reg_op(1'b0, 12'h0C0, 0, 1'b0, rd, er, rsp);
        chk(rd == 0, "R9 non-secure write no effect", rd, 0);
        reg_op(1'b1, 12'h0C0, GRANT_PAT[31:0], 1'b1, rd, er, rsp);
        chk(!er, "R9 secure grant write", er, 0);
        reg_op(1'b1, 12'h0C4, GRANT_PAT[63:32], 1'b1, rd, er, rsp);
        reg_op(1'b1, 12'h0C0, 32'h0, 1'b1, rd, er, rsp);

        // R10: seal the map
        @(negedge clk); grant_lock = 1'b1;
        @(negedge clk); grant_lock = 1'b0;
        reg_op(1'b1, 12'h0C0, 32'hFFFF_FFFF, 1'b1, rd, er, rsp);
        chk(er, "R10 write after seal rejected", er, 1);
        reg_op(1'b1, 12'h0C4, 32'h0000_FF00, 1'b1, rd, er, rsp);
        chk(er, "R10 write after seal rejected", er, 1);
        reg_op(1'b0, 12'h0C0, 0, 1'b0, rd, er, rsp);
        chk(rd == GRANT_PAT[31:0], "R10 grant bank0 frozen", rd, GRANT_PAT[31:0]);
        reg_op(1'b0, 12'h0C4, 0, 1'b0, rd, er, rsp);
        chk(rd == GRANT_PAT[63:32], "R10 grant bank1 frozen", rd, GRANT_PAT[63:32]);

        // R8: grant sweep, both security attributes
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < NW + 4; i++) begin
                bit eg;
                eg = (i < NW) && ((s == 1) || (i < UB) || GRANT_PAT[(i - UB) & 63]);
                query(i, 0, s[0], lk, gr, qe, vl);
                chk(gr == eg, "R8 access grant", gr, eg);
            end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule